// File: doc/BRIEF.md
# Peripheral ROM Window Decoder

This block sits on the read path of an 8-bit system with seven expansion slots. For each CPU access in the 0xC100–0xCFFF range it names the ROM that answers: the built-in firmware ROM, the 256-byte page ROM of one slot, or the 2 KB expansion ROM that slots share in 0xC800–0xCFFF. It also returns the slot number and the byte offset into the chosen ROM. The ROM arrays themselves lie outside the block.

The shared expansion window has no explicit select register. A slot claims it by any access to its own page. An access to 0xCFFF gives it up, and that release already applies to the access that makes it. Two mode inputs steer accesses to internal ROM. One covers the whole range. The other covers only the slot-3 page and the expansion window while slot 3 owns it. A read with no mapped source gets a fixed fill byte, and writes never read any ROM.

Top module: `pcrom_window_dec`

## Requirements
- R1: Addresses outside 0xC100–0xCFFF give source code 0 (none), slot 0 and offset 0, and raise neither `rom_rd` nor `fill_en`. Source codes are 0 = none, 1 = internal ROM, 2 = slot page ROM, 3 = slot expansion ROM.
- R2: While `int_rom_all` is 1, every address in 0xC100–0xCFFF gives source 1, slot 0 and offset = address − 0xC000. Such accesses leave the window owner unchanged.
- R3: An address in 0xC100–0xC7FF gives source 2, slot = address bits 10:8 and offset = address bits 7:0, unless R2 or R7 applies.
- R4: A valid access (read or write) to 0xC100–0xC7FF with `int_rom_all` at 0 makes slot bits 10:8 the window owner from the next clock edge on. Without `acc_valid` the owner does not change.
- R5: An address in 0xC800–0xCFFE with owner 1–7 gives source 3, slot = owner and offset = address − 0xC800, unless R2 or R7 applies.
- R6: Address 0xCFFF, with `int_rom_all` at 0, is decoded as if the owner were 0 in that same cycle, so it gives source 0. After a valid access to it, the owner is 0.
- R7: With `slot3_card` at 0, pages 0xC300–0xC3FF and expansion accesses while slot 3 is owner give source 1, slot 0 and offset = address − 0xC000. A 0xC3xx access still records owner 3.
- R8: An expansion-window access while the owner is 0 gives source 0.
- R9: A valid read asserts `rom_rd` when the source is non-zero. Otherwise it asserts `fill_en`, and `fill_data` carries 0xF4.
- R10: A valid write asserts neither `rom_rd` nor `fill_en`, so no ROM is read or changed.
- R11: After reset the owner is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | CPU address |
| acc_valid | input | 1 | Access strobe for this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| int_rom_all | input | 1 | Whole range served by internal ROM |
| slot3_card | input | 1 | 1 = slot 3 uses its card ROM, 0 = internal ROM |
| src_sel | output | 2 | Source code (R1) |
| slot_num | output | 3 | Selected slot |
| rom_offset | output | 12 | Byte offset into the selected ROM |
| rom_rd | output | 1 | Read enable for the selected ROM |
| fill_en | output | 1 | Drive the fill byte onto the bus |
| fill_data | output | 8 | Fill byte, 0xF4 |

## Verification
The source code, slot, offset and strobes are combinational and are due in the same cycle as the address. The bench drives inputs just after a falling edge and samples a few nanoseconds later, before the next rising edge. A change of owner takes one rising edge. The bench's reference model updates its owner only after that edge, so the first access that can see a new owner is the one in the next cycle.

// File: rtl/pcrom_pkg.sv
package pcrom_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_INT  = 2'd1,
      SRC_PAGE = 2'd2,
      SRC_EXP  = 2'd3
   } rom_src_e;
endpackage

// File: rtl/pcrom_addr_class.sv
module pcrom_addr_class #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_win,
   output logic              is_page,
   output logic              is_exp,
   output logic              is_release
);
   localparam logic [ADDR_W-1:0] WIN_LO  = ADDR_W'(16'hC100);
   localparam logic [ADDR_W-1:0] PAGE_HI = ADDR_W'(16'hC7FF);
   localparam logic [ADDR_W-1:0] EXP_LO  = ADDR_W'(16'hC800);
   localparam logic [ADDR_W-1:0] WIN_HI  = ADDR_W'(16'hCFFF);

   initial begin
      if (ADDR_W != 16) $error("pcrom_addr_class: ADDR_W must be 16");
   end

   always_comb begin
      in_win     = (addr >= WIN_LO) && (addr <= WIN_HI);
      is_page    = (addr >= WIN_LO) && (addr <= PAGE_HI);
      is_exp     = (addr >= EXP_LO) && (addr <= WIN_HI);
      is_release = (addr == WIN_HI);
   end
endmodule

// File: rtl/pcrom_owner_track.sv
module pcrom_owner_track #(
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              int_rom_all,
   input  logic              is_page,
   input  logic              is_release,
   input  logic [SLOT_W-1:0] page_slot,
   output logic [SLOT_W-1:0] owner_q,
   output logic [SLOT_W-1:0] owner_eff
);
   logic claim, release_acc;

   always_comb begin
      claim       = acc_valid && !int_rom_all && is_page;
      release_acc = acc_valid && !int_rom_all && is_release;
      owner_eff   = (is_release && !int_rom_all) ? '0 : owner_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           owner_q <= '0;
      else if (claim)       owner_q <= page_slot;
      else if (release_acc) owner_q <= '0;
   end
endmodule

// File: rtl/pcrom_src_pick.sv
module pcrom_src_pick
   import pcrom_pkg::*;
#(
   parameter int    ADDR_W       = 16,
   parameter int    SLOT_W       = 3,
   parameter int    OFF_W        = 12,
   parameter int    ALT_SLOT     = 3,
   parameter bit    HAS_ALT_SLOT = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              in_win,
   input  logic              is_page,
   input  logic              is_exp,
   input  logic              int_rom_all,
   input  logic              slot3_card,
   input  logic [SLOT_W-1:0] owner_eff,
   output rom_src_e          src,
   output logic [SLOT_W-1:0] slot,
   output logic [OFF_W-1:0]  offset
);
   localparam int PAGE_BITS = 8;
   localparam int EXP_BITS  = 11;
   localparam logic [SLOT_W-1:0] ALT_ID = SLOT_W'(ALT_SLOT);

   logic [SLOT_W-1:0] page_slot;
   logic              alt_redirect;

   assign page_slot = addr[PAGE_BITS +: SLOT_W];

   generate
      if (HAS_ALT_SLOT) begin : g_alt
         always_comb
            alt_redirect = !slot3_card &&
                           ((is_page && page_slot == ALT_ID) ||
                            (is_exp && owner_eff == ALT_ID));
      end else begin : g_no_alt
         logic unused_sw;
         assign unused_sw    = slot3_card;
         assign alt_redirect = 1'b0;
      end
   endgenerate

   always_comb begin
      src    = SRC_NONE;
      slot   = '0;
      offset = '0;
      if (in_win) begin
         if (int_rom_all || alt_redirect) begin
            src    = SRC_INT;
            offset = addr[OFF_W-1:0];
         end else if (is_page) begin
            src    = SRC_PAGE;
            slot   = page_slot;
            offset = OFF_W'(addr[PAGE_BITS-1:0]);
         end else if (owner_eff != '0) begin
            src    = SRC_EXP;
            slot   = owner_eff;
            offset = OFF_W'(addr[EXP_BITS-1:0]);
         end
      end
   end
endmodule

// File: rtl/pcrom_window_dec.sv
module pcrom_window_dec
   import pcrom_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter int          SLOT_W       = 3,
   parameter int          OFF_W        = 12,
   parameter int          DATA_W       = 8,
   parameter logic [7:0]  FILL_BYTE    = 8'hF4,
   parameter bit          HAS_ALT_SLOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              int_rom_all,
   input  logic              slot3_card,
   output logic [1:0]        src_sel,
   output logic [SLOT_W-1:0] slot_num,
   output logic [OFF_W-1:0]  rom_offset,
   output logic              rom_rd,
   output logic              fill_en,
   output logic [DATA_W-1:0] fill_data
);
   initial begin
      if (SLOT_W != 3)  $error("pcrom_window_dec: SLOT_W must be 3");
      if (OFF_W < 12)   $error("pcrom_window_dec: OFF_W must be at least 12");
      if (DATA_W < 8)   $error("pcrom_window_dec: DATA_W must be at least 8");
   end

   logic              in_win, is_page, is_exp, is_release;
   logic [SLOT_W-1:0] owner_q, owner_eff;
   rom_src_e          src;

   pcrom_addr_class #(.ADDR_W(ADDR_W)) u_class (
      .addr(addr), .in_win(in_win), .is_page(is_page),
      .is_exp(is_exp), .is_release(is_release)
   );

   pcrom_owner_track #(.SLOT_W(SLOT_W)) u_owner (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
      .int_rom_all(int_rom_all), .is_page(is_page),
      .is_release(is_release), .page_slot(addr[8 +: SLOT_W]),
      .owner_q(owner_q), .owner_eff(owner_eff)
   );

   pcrom_src_pick #(
      .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .OFF_W(OFF_W),
      .HAS_ALT_SLOT(HAS_ALT_SLOT)
   ) u_pick (
      .addr(addr), .in_win(in_win), .is_page(is_page), .is_exp(is_exp),
      .int_rom_all(int_rom_all), .slot3_card(slot3_card),
      .owner_eff(owner_eff), .src(src), .slot(slot_num),
      .offset(rom_offset)
   );

   always_comb begin
      src_sel   = src;
      rom_rd    = acc_valid && !acc_write && (src != SRC_NONE);
      fill_en   = acc_valid && !acc_write && in_win && (src == SRC_NONE);
      fill_data = DATA_W'(FILL_BYTE);
   end
endmodule

module pcrom_window_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] addr,
   input logic        acc_valid,
   input logic        acc_write,
   input logic        int_rom_all,
   input logic [1:0]  src_sel,
   input logic        rom_rd,
   input logic        fill_en,
   input logic [2:0]  owner
);
   // R1
   out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr < 16'hC100 || addr > 16'hCFFF) |-> (src_sel == 2'd0 && !rom_rd && !fill_en));
   // R2
   int_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_rom_all && addr >= 16'hC100 && addr <= 16'hCFFF) |-> src_sel == 2'd1);
   // R2
   int_all_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_rom_all |=> $stable(owner));
   // R4
   claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !int_rom_all && addr >= 16'hC100 && addr <= 16'hC7FF)
      |=> owner == $past(addr[10:8]));
   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> $stable(owner));
   // R6
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !int_rom_all && addr == 16'hCFFF) |=> owner == 3'd0);
   // R6
   release_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_rom_all && addr == 16'hCFFF) |-> src_sel == 2'd0);
   // R10
   write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write) |-> (!rom_rd && !fill_en));
   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_rd, fill_en}));
endmodule

bind pcrom_window_dec pcrom_window_chk u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .acc_valid(acc_valid),
   .acc_write(acc_write), .int_rom_all(int_rom_all), .src_sel(src_sel),
   .rom_rd(rom_rd), .fill_en(fill_en), .owner(owner_q)
);

// File: tb/tb_pcrom_window_dec.sv
module tb_pcrom_window_dec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic        int_rom_all = 1'b0, slot3_card = 1'b1;
   logic [1:0]  src_sel;
   logic [2:0]  slot_num;
   logic [11:0] rom_offset;
   logic        rom_rd, fill_en;
   logic [7:0]  fill_data;

   int total = 0, bad = 0;
   logic [2:0] m_owner = 3'd0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pcrom_window_dec dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .acc_valid(acc_valid),
      .acc_write(acc_write), .int_rom_all(int_rom_all),
      .slot3_card(slot3_card), .src_sel(src_sel), .slot_num(slot_num),
      .rom_offset(rom_offset), .rom_rd(rom_rd), .fill_en(fill_en),
      .fill_data(fill_data)
   );

   // expected {src, slot, offset}
   function automatic logic [16:0] model(input logic [15:0] a, input logic ia,
                                          input logic s3, input logic [2:0] own);
      logic [2:0] eo;
      if (a < 16'hC100 || a > 16'hCFFF) return '0;                  // R1
      if (ia) return {2'd1, 3'd0, a[11:0]};                         // R2
      eo = (a == 16'hCFFF) ? 3'd0 : own;                            // R6
      if (a <= 16'hC7FF) begin
         if (!s3 && a[10:8] == 3'd3) return {2'd1, 3'd0, a[11:0]};  // R7
         return {2'd2, a[10:8], 4'd0, a[7:0]};                      // R3
      end
      if (!s3 && eo == 3'd3) return {2'd1, 3'd0, a[11:0]};          // R7
      if (eo == 3'd0) return '0;                                    // R8
      return {2'd3, eo, 1'b0, a[10:0]};                             // R5
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
      end
   endtask

   task automatic acc(input logic [15:0] a, input logic v, input logic w,
                      input logic ia, input logic s3, input string req);
      logic [16:0] e;
      logic in_w;
      @(negedge clk);
      addr = a; acc_valid = v; acc_write = w; int_rom_all = ia; slot3_card = s3;
      #2;
      e = model(a, ia, s3, m_owner);
      in_w = (a >= 16'hC100 && a <= 16'hCFFF);
      chk(req, {15'd0, src_sel, slot_num, rom_offset}, {15'd0, e});
      chk({req, "/R9 R10 strobes"}, {30'd0, rom_rd, fill_en},
          {30'd0, v && !w && e[16:15] != 2'd0, v && !w && in_w && e[16:15] == 2'd0});
      if (v && !w && e[16:15] == 2'd0 && in_w) chk("R9 fill", {24'd0, fill_data}, 32'hF4);
      @(posedge clk);
      if (v && !ia) begin
         if (a >= 16'hC100 && a <= 16'hC7FF) m_owner = a[10:8];   // R4
         else if (a == 16'hCFFF) m_owner = 3'd0;                  // R6
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] a;
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R11 reset owner 0: expansion read gives none
      acc(16'hC900, 1, 0, 0, 1, "R11");
      acc(16'hC000, 1, 0, 0, 1, "R1");
      acc(16'hD000, 1, 0, 0, 1, "R1");
      acc(16'hC0FF, 1, 0, 0, 1, "R1");
      acc(16'hC5A7, 1, 0, 0, 1, "R3");
      acc(16'hC812, 1, 0, 0, 1, "R5");
      acc(16'hCFFE, 1, 0, 0, 1, "R5");
      acc(16'hC200, 0, 0, 0, 1, "R4 no valid");
      acc(16'hC800, 1, 0, 0, 1, "R4 owner held");
      acc(16'hC7FF, 1, 1, 0, 1, "R10 write claims");
      acc(16'hCABC, 1, 0, 0, 1, "R4");
      acc(16'hCFFF, 1, 0, 0, 1, "R6");
      acc(16'hC800, 1, 0, 0, 1, "R8");
      acc(16'hC100, 1, 0, 1, 1, "R2");
      acc(16'hCFFF, 1, 0, 1, 1, "R2");
      acc(16'hC801, 1, 0, 0, 1, "R2 owner kept");
      acc(16'hC3C3, 1, 0, 0, 0, "R7 page");
      acc(16'hC844, 1, 0, 0, 0, "R7 exp");
      acc(16'hC844, 1, 0, 0, 1, "R5 s3 card");
      acc(16'hCFFF, 1, 1, 0, 0, "R6 R10 write");
      acc(16'hC844, 1, 0, 0, 0, "R8");
      for (int i = 0; i < 3000; i++) begin
         case ($urandom_range(0, 9))
            0:       a = 16'hCFFF;
            1:       a = 16'($urandom_range(0, 16'hFFFF));
            2, 3, 4: a = 16'($urandom_range(16'hC100, 16'hC7FF));
            default: a = 16'($urandom_range(16'hC800, 16'hCFFF));
         endcase
         acc(a, $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
             $urandom_range(0, 7) == 0, $urandom_range(0, 2) != 0, "R3 R5 R7 random");
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule